// File: doc/BRIEF.md
# Accumulator CPU Instruction Decoder

This block turns a 16-bit instruction word of a small 8-bit register machine into the control signals its datapath needs. It picks one of two words to decode: the normal instruction-register value, or a word shifted in over a debug scan path. That choice lets a host drive the machine one instruction at a time without touching program memory. The decoded controls are a 3-bit common source select, which every register input multiplexer shares, one load enable per general register, a program-counter load enable, a memory write strobe, a program-counter step strobe and the 8-bit immediate.

A hold-off control blocks every side effect of the decoded word. It is used while a debugger rewrites the instruction register, so a half-written word cannot load a register or write memory. The decode is registered: every output reflects the inputs sampled at the previous rising clock edge. A synchronous, active-high reset clears all outputs.

Word layout: bits 15:13 are the source code, bits 12:10 the destination code, bit 9 the write strobe, bit 8 the step strobe and bits 7:0 the immediate. Source codes 0 to 3 pick general registers 0 to 3. Code 4 picks the destination's own value, 5 the immediate, 6 the memory or adder path and 7 the register's shadow copy.

Top module: `acd_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: After each edge without reset, `src_sel` equals bits 15:13 of the chosen word, and this holds whether or not `hold_off` is high.
- R3: A destination code (bits 12:10) of 0 to 3 sets only `gpr_load[code]` and leaves `pc_load` low.
- R4: Destination code 4 sets `pc_load` and leaves all of `gpr_load` low.
- R5: Destination codes 5, 6 and 7 leave every load enable low.
- R6: `mem_we` equals bit 9 and `pc_step` equals bit 8 of the chosen word.
- R7: `imm` equals bits 7:0 of the chosen word, whatever the state of `hold_off`.
- R8: When `use_scan` is high, `scan_word` is decoded and `ir_word` has no effect on any output. When `use_scan` is low, `ir_word` is decoded and `scan_word` has no effect.
- R9: When `hold_off` is high, `gpr_load`, `pc_load`, `mem_we` and `pc_step` are all low.
- R10: The all-zero word gives `src_sel` = 0, `gpr_load` = 4'b0001 and no other strobe, so register 0 reloads itself (a no-op).
- R11: At most one of `gpr_load` and `pc_load` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_word | input | 16 | Word held in the instruction register |
| scan_word | input | 16 | Alternative word from the debug scan path |
| use_scan | input | 1 | High: decode `scan_word` in place of `ir_word` |
| hold_off | input | 1 | High: block all loads and strobes |
| src_sel | output | 3 | Common source select for register input multiplexers |
| gpr_load | output | 4 | Load enables for general registers 0 to 3 |
| pc_load | output | 1 | Program-counter load enable |
| mem_we | output | 1 | Memory write strobe |
| pc_step | output | 1 | Program-counter increment strobe |
| imm | output | 8 | Immediate data |

## Verification
The checker watches every cycle. It checks that no more than one load enable is high, that hold-off blocks all strobes, and that the select, immediate and strobe bits follow the chosen word with one cycle of delay. It also checks that unused destination codes load nothing and that outputs are zero after reset. Some behaviours show up only in the bench scenarios, which compare each output field against a behavioural model. These are the full sweep of source and destination codes, the exact one-hot position for each destination, the no-op word, the point that the word not chosen cannot disturb any output, and a reset applied in the middle of a run.

// File: rtl/acd_pkg.sv
package acd_pkg;
  // Source select meanings (codes shared by every register input mux)
  localparam int unsigned SRC_SELF   = 4;
  localparam int unsigned SRC_IMM    = 5;
  localparam int unsigned SRC_ALT    = 6;
  localparam int unsigned SRC_SHADOW = 7;

  // Strobe positions above the immediate field
  localparam int unsigned STEP_OFS = 0;
  localparam int unsigned WE_OFS   = 1;
  localparam int unsigned FLAG_W   = 2;

  // Width of a full instruction word for given field widths
  function automatic int unsigned word_width(int unsigned data_w,
                                             int unsigned sel_w,
                                             int unsigned dest_w);
    return data_w + FLAG_W + dest_w + sel_w;
  endfunction
endpackage

// File: rtl/acd_word_select.sv
module acd_word_select #(
  parameter int unsigned IW = 16
) (
  input  logic [IW-1:0] ir_word,
  input  logic [IW-1:0] scan_word,
  input  logic          use_scan,
  output logic [IW-1:0] word
);
  always_comb begin
    word = use_scan ? scan_word : ir_word;
  end
endmodule

// File: rtl/acd_field_split.sv
module acd_field_split
  import acd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DEST_W  = 3,
  parameter int unsigned NUM_GPR = 4,
  localparam int unsigned IW     = word_width(DATA_W, SEL_W, DEST_W)
) (
  input  logic [IW-1:0]      word,
  output logic [SEL_W-1:0]   src,
  output logic [NUM_GPR-1:0] gpr_hit,
  output logic               pc_hit,
  output logic               we_bit,
  output logic               step_bit,
  output logic [DATA_W-1:0]  imm
);
  localparam int unsigned DST_LO = DATA_W + FLAG_W;
  localparam int unsigned SRC_LO = DST_LO + DEST_W;

  logic [DEST_W-1:0] dst;

  always_comb begin
    src      = word[SRC_LO +: SEL_W];
    dst      = word[DST_LO +: DEST_W];
    we_bit   = word[DATA_W + WE_OFS];
    step_bit = word[DATA_W + STEP_OFS];
    imm      = word[DATA_W-1:0];
    pc_hit   = (dst == DEST_W'(NUM_GPR));
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_dst
    assign gpr_hit[g] = (dst == DEST_W'(g));
  end
endmodule

// File: rtl/acd_enable_gate.sv
module acd_enable_gate #(
  parameter int unsigned N = 7
) (
  input  logic         hold,
  input  logic [N-1:0] en_in,
  output logic [N-1:0] en_out
);
  for (genvar k = 0; k < N; k++) begin : g_gate
    assign en_out[k] = en_in[k] & ~hold;
  end
endmodule

// File: rtl/acd_decoder.sv
module acd_decoder
  import acd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DEST_W  = 3,
  parameter int unsigned NUM_GPR = 4,
  localparam int unsigned IW     = word_width(DATA_W, SEL_W, DEST_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IW-1:0]      ir_word,
  input  logic [IW-1:0]      scan_word,
  input  logic               use_scan,
  input  logic               hold_off,
  output logic [SEL_W-1:0]   src_sel,
  output logic [NUM_GPR-1:0] gpr_load,
  output logic               pc_load,
  output logic               mem_we,
  output logic               pc_step,
  output logic [DATA_W-1:0]  imm
);
  // Strobe vector: {step, we, pc, gpr...}
  localparam int unsigned EN_N = NUM_GPR + 3;

  logic [IW-1:0]      word;
  logic [SEL_W-1:0]   src_c;
  logic [NUM_GPR-1:0] gpr_c;
  logic               pc_c;
  logic               we_c;
  logic               step_c;
  logic [DATA_W-1:0]  imm_c;
  logic [EN_N-1:0]    en_raw;
  logic [EN_N-1:0]    en_gated;

  acd_word_select #(.IW(IW)) u_pick (
    .ir_word  (ir_word),
    .scan_word(scan_word),
    .use_scan (use_scan),
    .word     (word)
  );

  acd_field_split #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .DEST_W (DEST_W),
    .NUM_GPR(NUM_GPR)
  ) u_split (
    .word    (word),
    .src     (src_c),
    .gpr_hit (gpr_c),
    .pc_hit  (pc_c),
    .we_bit  (we_c),
    .step_bit(step_c),
    .imm     (imm_c)
  );

  assign en_raw = {step_c, we_c, pc_c, gpr_c};

  acd_enable_gate #(.N(EN_N)) u_gate (
    .hold  (hold_off),
    .en_in (en_raw),
    .en_out(en_gated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel  <= '0;
      gpr_load <= '0;
      pc_load  <= 1'b0;
      mem_we   <= 1'b0;
      pc_step  <= 1'b0;
      imm      <= '0;
    end else begin
      src_sel  <= src_c;
      gpr_load <= en_gated[NUM_GPR-1:0];
      pc_load  <= en_gated[NUM_GPR];
      mem_we   <= en_gated[NUM_GPR+1];
      pc_step  <= en_gated[NUM_GPR+2];
      imm      <= imm_c;
    end
  end
endmodule

// File: rtl/acd_decoder_chk.sv
module acd_decoder_chk
  import acd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DEST_W  = 3,
  parameter int unsigned NUM_GPR = 4,
  localparam int unsigned IW     = word_width(DATA_W, SEL_W, DEST_W)
) (
  input logic               clk,
  input logic               rst,
  input logic [IW-1:0]      ir_word,
  input logic [IW-1:0]      scan_word,
  input logic               use_scan,
  input logic               hold_off,
  input logic [SEL_W-1:0]   src_sel,
  input logic [NUM_GPR-1:0] gpr_load,
  input logic               pc_load,
  input logic               mem_we,
  input logic               pc_step,
  input logic [DATA_W-1:0]  imm
);
  localparam int unsigned DST_LO = DATA_W + FLAG_W;
  localparam int unsigned SRC_LO = DST_LO + DEST_W;

  logic [IW-1:0] seen;
  assign seen = use_scan ? scan_word : ir_word;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (src_sel == '0 && gpr_load == '0 && !pc_load
                    && !mem_we && !pc_step && imm == '0));

  p_src_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> src_sel == $past(seen[SRC_LO +: SEL_W]));

  p_null_dest_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(seen[DST_LO +: DEST_W]) > DEST_W'(NUM_GPR))
      |-> (gpr_load == '0 && !pc_load));

  p_strobes_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hold_off))
      |-> (mem_we == $past(seen[DATA_W + WE_OFS])
           && pc_step == $past(seen[DATA_W + STEP_OFS])));

  p_imm_follow_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> imm == $past(seen[DATA_W-1:0]));

  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(hold_off) |-> (gpr_load == '0 && !pc_load && !mem_we && !pc_step));

  p_single_load_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_load, gpr_load}));
endmodule

bind acd_decoder acd_decoder_chk #(
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .DEST_W (DEST_W),
  .NUM_GPR(NUM_GPR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ir_word  (ir_word),
  .scan_word(scan_word),
  .use_scan (use_scan),
  .hold_off (hold_off),
  .src_sel  (src_sel),
  .gpr_load (gpr_load),
  .pc_load  (pc_load),
  .mem_we   (mem_we),
  .pc_step  (pc_step),
  .imm      (imm)
);

// File: tb/acd_decoder_bench.sv
`timescale 1ns/1ps
module acd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ir_word = '0;
  logic [15:0] scan_word = '0;
  logic        use_scan = 1'b0;
  logic        hold_off = 1'b0;
  logic [2:0]  src_sel;
  logic [3:0]  gpr_load;
  logic        pc_load, mem_we, pc_step;
  logic [7:0]  imm;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  acd_decoder u_acd_decoder (
    .clk(clk), .rst(rst), .ir_word(ir_word), .scan_word(scan_word),
    .use_scan(use_scan), .hold_off(hold_off), .src_sel(src_sel),
    .gpr_load(gpr_load), .pc_load(pc_load), .mem_we(mem_we),
    .pc_step(pc_step), .imm(imm)
  );

  // Behavioural reference: expectations captured at each rising edge
  bit    ev = 0;
  int    e_src, e_gpr, e_pc, e_we, e_step, e_imm;
  string t_src, t_gpr, t_pc, t_flag, t_imm;

  always @(posedge clk) begin
    int w, d;
    ev = 1;
    if (rst) begin
      e_src = 0; e_gpr = 0; e_pc = 0; e_we = 0; e_step = 0; e_imm = 0;
      t_src = "R1"; t_gpr = "R1"; t_pc = "R1"; t_flag = "R1"; t_imm = "R1";
    end else begin
      w = use_scan ? int'(scan_word) : int'(ir_word);
      d = (w / 1024) % 8;
      e_src  = w / 8192;
      e_imm  = w % 256;
      e_we   = (w / 512) % 2;
      e_step = (w / 256) % 2;
      e_gpr  = (d < 4) ? (1 << d) : 0;
      e_pc   = (d == 4) ? 1 : 0;
      t_src  = use_scan ? "R8 src R2" : "src R2";
      t_imm  = use_scan ? "R8 imm R7" : "imm R7";
      t_flag = "flags R6";
      t_gpr  = (d < 4) ? "gpr R3" : ((d == 4) ? "gpr R4" : "gpr R5");
      t_pc   = (d == 4) ? "pc R4" : "pc R5";
      if (w == 0) begin
        t_gpr = "no-op R10";
        t_src = "no-op R10";
      end
      if (hold_off) begin
        e_gpr = 0; e_pc = 0; e_we = 0; e_step = 0;
        t_gpr = "hold R9"; t_pc = "hold R9"; t_flag = "hold R9";
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (ev && !finished) begin
      cmp(t_src,  int'(src_sel),  e_src);
      cmp(t_gpr,  int'(gpr_load), e_gpr);
      cmp(t_pc,   int'(pc_load),  e_pc);
      cmp({t_flag, " we"},   int'(mem_we),  e_we);
      cmp({t_flag, " step"}, int'(pc_step), e_step);
      cmp(t_imm,  int'(imm),      e_imm);
      cmp("R11 single load", ($countones({pc_load, gpr_load}) <= 1) ? 1 : 0, 1);
    end
  end

  task automatic drive(logic [15:0] iw, logic [15:0] sw, logic us, logic ho);
    @(negedge clk);
    #1;
    ir_word = iw; scan_word = sw; use_scan = us; hold_off = ho;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    ir_word = 16'hFFFF;   // reset must clear outputs regardless (R1)
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R10: the all-zero word is a no-op reloading register 0
    drive(16'h0000, 16'hFFFF, 1'b0, 1'b0);
    drive(16'h0000, 16'h0000, 1'b1, 1'b0);
    // R2 R3 R4 R5 R6 R7: sweep every source, destination and strobe pair
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++)
        for (int f = 0; f < 4; f++)
          drive(16'((s << 13) | (d << 10) | (f << 8) | ((s * 37 + d * 11 + f) % 256)),
                16'hFFFF, 1'b0, 1'b0);
    // R8: scan word decoded, instruction register word varied and ignored
    for (int d = 0; d < 8; d++) begin
      drive(16'hFFFF, 16'((d << 13) | (d << 10) | 16'h0355), 1'b1, 1'b0);
      drive(16'h0000, 16'((d << 13) | (d << 10) | 16'h0355), 1'b1, 1'b0);
    end
    // R8: scan word varied and ignored when not selected
    drive(16'h1122, 16'hFFFF, 1'b0, 1'b0);
    drive(16'h1122, 16'h0000, 1'b0, 1'b0);
    // R9: hold-off silences every strobe but select and immediate still follow
    for (int d = 0; d < 8; d++) begin
      drive(16'((d << 13) | (d << 10) | 16'h03A5), 16'h0000, 1'b0, 1'b1);
      drive(16'h0000, 16'((d << 10) | 16'h0300), 1'b1, 1'b1);
    end
    // R1: reset in the middle of a run
    drive(16'h3F7E, 16'h0, 1'b0, 1'b0);
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 rst = 1'b0;
    // mixed patterns from an LFSR
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf, {lf[7:0], lf[15:8]}, lf[3] & lf[6], lf[1] & lf[9] & lf[4]);
    end
    drive(16'h0, 16'h0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    #2 finish_run();
  end

  initial begin
    #(50000 * 10);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule